// File: doc/BRIEF.md
# Ones-Density Calibration Sequencer

This block runs offset and gain calibration for a single-bit oversampled converter front end. On a start command it first asks for a modulator reset, so that calibration begins from a known state. It then forces the front end into its zero-input mode, waits for the loop to settle, and counts the ones in a fixed window of valid bits. Next it forces gain-calibration mode, waits again, and counts a second window. Each error word is the measured ones count minus the count an ideal modulator would give for that step and input range.

The ideal ones density depends on the step and on the input range. In the zero step it is one half for the bipolar range and three eighths for the unipolar range. In the gain step it is five eighths. The window is a power of two, so every ideal count is an exact shift of the window size. Results belong to the input range that was selected when the run began. Any change of that range makes them stale, and a change during a run abandons the run. Applying the corrections to the data path is done elsewhere.

Top module: `odcal_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `mod_reset`, `zero_force`, `gain_force`, `res_pulse` and `res_valid` are low, and both error words are zero.
- R2: A `start` sampled while idle makes `mod_reset` high for exactly RST_CYC cycles, beginning with the next cycle. `busy` is high from that cycle until the block is idle again, which is 2·SETTLE_CYC + 2·2^WIN_LOG2 + RST_CYC + 1 cycles for an undisturbed run. A `start` while busy is ignored.
- R3: After the reset request, `zero_force` is high for SETTLE_CYC cycles in which no bit is counted. It stays high while 2^WIN_LOG2 bits are taken, one per cycle with `bit_vld` high.
- R4: `offset_err` becomes (ones in the zero window) − ideal, as two's complement with WIN_LOG2+2 bits. The ideal is 2^(WIN_LOG2-1) when `bip_mode`=1 (bipolar) and 3·2^(WIN_LOG2-3) when `bip_mode`=0 (unipolar).
- R5: After the zero window, `gain_force` is high for SETTLE_CYC uncounted cycles, then for a window of 2^WIN_LOG2 bits. `gain_err` becomes (ones in that window) − 5·2^(WIN_LOG2-3), with the same format as R4.
- R6: At most one of `mod_reset`, `zero_force` and `gain_force` is high in any cycle.
- R7: If `bit_vld` is low in a counting cycle, the partial count is discarded and that step restarts with its full settle wait.
- R8: A completed run ends with one cycle in which `res_pulse` is high and `res_valid` rises. The block is idle in the next cycle.
- R9: `res_valid` drops one cycle after `bip_mode` differs from the value it had at the start of the run. A new `start` also clears it.
- R10: A change of `bip_mode` during a run returns the block to idle with `res_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one modulator bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Modulator output bit |
| bit_vld | input | 1 | Bit is trustworthy this cycle |
| bip_mode | input | 1 | 1 = bipolar input range, 0 = unipolar |
| start | input | 1 | Begin a calibration run (used only while idle) |
| mod_reset | output | 1 | Request to reset the modulator loop |
| zero_force | output | 1 | Force the front end to its zero-input mode |
| gain_force | output | 1 | Force the front end to its gain-calibration mode |
| busy | output | 1 | A run is in progress |
| res_pulse | output | 1 | One-cycle pulse when a run completes |
| res_valid | output | 1 | Error words are current for the present input range |
| offset_err | output | WIN_LOG2+2 | Signed zero-step error |
| gain_err | output | WIN_LOG2+2 | Signed gain-step error |

## Verification
Every control output and flag is registered. Each one therefore changes in the cycle right after the clock edge that samples the stimulus: the reset request one cycle after `start`, the zero mode after RST_CYC cycles, and each count window only after a full SETTLE_CYC wait. The bench keeps a behavioural model that steps on the same edge and compares all outputs one nanosecond after every rising edge. A dropped `bit_vld` or a range change is therefore seen in exactly the cycle it takes effect. The error words and `res_valid` are also checked against hand-computed values once `busy` falls, and the busy length of a run is compared with the cycle count stated in R2.

// File: rtl/odcal_pkg.sv
package odcal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST,
        ST_ZSET,
        ST_ZCNT,
        ST_GSET,
        ST_GCNT,
        ST_DONE
    } odcal_state_e;
endpackage

// File: rtl/odcal_timer.sv
module odcal_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (en)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/odcal_ones_acc.sv
module odcal_ones_acc #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          take,
    input  logic          bit_in,
    output logic [CW-1:0] ones,
    output logic [CW-1:0] taken
);
    typedef struct packed {
        logic [CW-1:0] ones;
        logic [CW-1:0] taken;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d.ones  = '0;
            acc_d.taken = '0;
        end else if (take) begin
            acc_d.ones  = acc_q.ones + CW'(bit_in);
            acc_d.taken = acc_q.taken + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else
            acc_q <= acc_d;
    end

    assign ones  = acc_q.ones;
    assign taken = acc_q.taken;
endmodule

// File: rtl/odcal_seq.sv
module odcal_seq
    import odcal_pkg::*;
#(
    parameter int WIN_LOG2   = 6,
    parameter int SETTLE_CYC = 1000,
    parameter int RST_CYC    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_in,
    input  logic                  bit_vld,
    input  logic                  bip_mode,
    input  logic                  start,
    output logic                  mod_reset,
    output logic                  zero_force,
    output logic                  gain_force,
    output logic                  busy,
    output logic                  res_pulse,
    output logic                  res_valid,
    output logic [WIN_LOG2+1:0]   offset_err,
    output logic [WIN_LOG2+1:0]   gain_err
);
    localparam int WIN    = 1 << WIN_LOG2;
    localparam int CW     = WIN_LOG2 + 1;
    localparam int EW     = CW + 1;
    localparam int TMAX   = (SETTLE_CYC > RST_CYC) ? SETTLE_CYC : RST_CYC;
    localparam int TW     = $clog2(TMAX + 1);
    localparam logic [CW-1:0] IDEAL_BIP  = CW'(WIN / 2);
    localparam logic [CW-1:0] IDEAL_UNI  = CW'((3 * WIN) / 8);
    localparam logic [CW-1:0] IDEAL_GAIN = CW'((5 * WIN) / 8);
    localparam logic [TW-1:0] RST_LAST   = TW'(RST_CYC - 1);
    localparam logic [TW-1:0] SET_LAST   = TW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] WIN_LAST   = CW'(WIN - 1);

    typedef struct packed {
        odcal_state_e  state;
        logic          cal_mode;
        logic          valid;
        logic [EW-1:0] off;
        logic [EW-1:0] gain;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          t_clr, t_en, a_clr, a_take;
    logic [TW-1:0] t_cnt;
    logic [CW-1:0] a_ones, a_taken;
    logic [CW-1:0] ones_nx, zero_ideal;
    logic signed [EW-1:0] zero_meas, gain_meas;
    logic          mode_miss, in_run, win_full;

    odcal_timer #(.W(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (t_clr),
        .en    (t_en),
        .cnt   (t_cnt)
    );

    odcal_ones_acc #(.CW(CW)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (a_clr),
        .take   (a_take),
        .bit_in (bit_in),
        .ones   (a_ones),
        .taken  (a_taken)
    );

    always_comb begin
        seq_d      = seq_q;
        t_clr      = 1'b0;
        t_en       = 1'b0;
        a_clr      = 1'b0;
        a_take     = 1'b0;
        ones_nx    = a_ones + CW'(bit_in);
        zero_ideal = seq_q.cal_mode ? IDEAL_BIP : IDEAL_UNI;
        zero_meas  = $signed(EW'(ones_nx)) - $signed(EW'(zero_ideal));
        gain_meas  = $signed(EW'(ones_nx)) - $signed(EW'(IDEAL_GAIN));
        mode_miss  = (bip_mode != seq_q.cal_mode);
        in_run     = (seq_q.state != ST_IDLE) && (seq_q.state != ST_DONE);
        win_full   = (a_taken == WIN_LAST);

        if (in_run && mode_miss) begin
            seq_d.state = ST_IDLE;
            t_clr       = 1'b1;
            a_clr       = 1'b1;
        end else begin
            unique case (seq_q.state)
                ST_IDLE: begin
                    t_clr = 1'b1;
                    a_clr = 1'b1;
                    if (start) begin
                        seq_d.state    = ST_RST;
                        seq_d.cal_mode = bip_mode;
                        seq_d.valid    = 1'b0;
                    end
                end
                ST_RST: begin
                    if (t_cnt == RST_LAST) begin
                        seq_d.state = ST_ZSET;
                        t_clr       = 1'b1;
                    end else begin
                        t_en = 1'b1;
                    end
                end
                ST_ZSET, ST_GSET: begin
                    a_clr = 1'b1;
                    if (t_cnt == SET_LAST) begin
                        seq_d.state = (seq_q.state == ST_ZSET) ? ST_ZCNT : ST_GCNT;
                        t_clr       = 1'b1;
                    end else begin
                        t_en = 1'b1;
                    end
                end
                ST_ZCNT, ST_GCNT: begin
                    t_clr = 1'b1;
                    if (!bit_vld) begin
                        seq_d.state = (seq_q.state == ST_ZCNT) ? ST_ZSET : ST_GSET;
                        a_clr       = 1'b1;
                    end else begin
                        a_take = 1'b1;
                        if (win_full) begin
                            if (seq_q.state == ST_ZCNT) begin
                                seq_d.off   = zero_meas;
                                seq_d.state = ST_GSET;
                            end else begin
                                seq_d.gain  = gain_meas;
                                seq_d.valid = 1'b1;
                                seq_d.state = ST_DONE;
                            end
                        end
                    end
                end
                ST_DONE: begin
                    seq_d.state = ST_IDLE;
                end
                default: seq_d.state = ST_IDLE;
            endcase
        end

        if (mode_miss)
            seq_d.valid = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state    <= ST_IDLE;
            seq_q.cal_mode <= 1'b0;
            seq_q.valid    <= 1'b0;
            seq_q.off      <= '0;
            seq_q.gain     <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mod_reset  = (seq_q.state == ST_RST);
    assign zero_force = (seq_q.state == ST_ZSET) || (seq_q.state == ST_ZCNT);
    assign gain_force = (seq_q.state == ST_GSET) || (seq_q.state == ST_GCNT);
    assign busy       = (seq_q.state != ST_IDLE);
    assign res_pulse  = (seq_q.state == ST_DONE);
    assign res_valid  = seq_q.valid;
    assign offset_err = seq_q.off;
    assign gain_err   = seq_q.gain;
endmodule

// File: rtl/odcal_seq_chk.sv
module odcal_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic bip_mode,
    input logic start,
    input logic mod_reset,
    input logic zero_force,
    input logic gain_force,
    input logic busy,
    input logic res_pulse,
    input logic res_valid
);
    AST_ONE_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(zero_force && gain_force)); // R6

    AST_RST_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        mod_reset |-> (!zero_force && !gain_force)); // R6

    AST_CTRL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_reset || zero_force || gain_force) |-> busy); // R2

    AST_RST_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_reset) |-> !$past(busy)); // R2

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_pulse |=> (!res_pulse && !busy)); // R8

    AST_PULSE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_pulse |-> res_valid); // R8

    AST_MODE_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && (bip_mode != $past(bip_mode))) |=> !res_valid); // R9
endmodule

bind odcal_seq odcal_seq_chk u_chk (.*);

// File: tb/sim_odcal_seq.sv
`timescale 1ns/1ps
module sim_odcal_seq;
    localparam int N      = 6;
    localparam int WIN    = 1 << N;
    localparam int SET    = 1000;
    localparam int RST    = 4;
    localparam int EW     = N + 2;
    localparam int RUNLEN = RST + 2 * SET + 2 * WIN + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0, bit_vld = 1'b1, bip_mode = 1'b1, start = 1'b0;
    logic mod_reset, zero_force, gain_force, busy, res_pulse, res_valid;
    logic [EW-1:0] offset_err, gain_err;

    int n_chk = 0, n_bad = 0, cyc = 0, pat = 0, bcnt = 0;

    always #2 clk = ~clk;

    odcal_seq #(.WIN_LOG2(N), .SETTLE_CYC(SET), .RST_CYC(RST)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .bip_mode(bip_mode), .start(start), .mod_reset(mod_reset),
        .zero_force(zero_force), .gain_force(gain_force), .busy(busy),
        .res_pulse(res_pulse), .res_valid(res_valid),
        .offset_err(offset_err), .gain_err(gain_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // behavioural reference: phase 0 idle,1 reset,2 zero wait,3 zero count,
    // 4 gain wait,5 gain count,6 done
    int m_phase = 0, m_left = 0, m_off = 0, m_gain = 0;
    bit m_cal = 1'b0, m_valid = 1'b0;
    int m_bits[$];

    function automatic int qsum();
        int s = 0;
        foreach (m_bits[i]) s += m_bits[i];
        return s;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_phase = 0; m_off = 0; m_gain = 0; m_cal = 1'b0; m_valid = 1'b0;
            m_bits.delete();
        end else begin
            bit chg;
            chg = (bip_mode != m_cal);
            if (m_phase >= 1 && m_phase <= 5 && chg) begin
                m_phase = 0;
            end else begin
                case (m_phase)
                    0: if (start) begin m_phase = 1; m_left = RST; m_cal = bip_mode; m_valid = 1'b0; end
                    1, 2, 4: begin
                        m_left--;
                        if (m_left == 0) begin
                            m_phase = (m_phase == 4) ? 5 : m_phase + 1;
                            m_left = SET;
                            m_bits.delete();
                        end
                    end
                    3, 5: begin
                        if (!bit_vld) begin
                            m_phase--; m_left = SET; m_bits.delete();
                        end else begin
                            m_bits.push_back(int'(bit_in));
                            if (m_bits.size() == WIN) begin
                                if (m_phase == 3) begin
                                    m_off = qsum() - (m_cal ? WIN / 2 : (3 * WIN) / 8);
                                    m_phase = 4; m_left = SET;
                                end else begin
                                    m_gain = qsum() - (5 * WIN) / 8;
                                    m_valid = 1'b1; m_phase = 6;
                                end
                            end
                        end
                    end
                    default: m_phase = 0;
                endcase
            end
            if (chg) m_valid = 1'b0;
        end
    end

    // per-cycle comparison one ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (busy) bcnt++;
        if (rst_n) begin
            chk(mod_reset == (m_phase == 1), "R2 mod_reset", mod_reset, m_phase == 1);
            chk(zero_force == (m_phase == 2 || m_phase == 3), "R3/R7 zero_force", zero_force, m_phase == 2 || m_phase == 3);
            chk(gain_force == (m_phase == 4 || m_phase == 5), "R5/R7 gain_force", gain_force, m_phase == 4 || m_phase == 5);
            chk(busy == (m_phase != 0), "R2/R10 busy", busy, m_phase != 0);
            chk(res_pulse == (m_phase == 6), "R8 res_pulse", res_pulse, m_phase == 6);
            chk(res_valid == m_valid, "R9 res_valid", res_valid, m_valid);
            chk($signed(offset_err) == m_off, "R4 offset_err", $signed(offset_err), m_off);
            chk($signed(gain_err) == m_gain, "R5 gain_err", $signed(gain_err), m_gain);
        end
    end

    always @(negedge clk) begin
        case (pat)
            0: bit_in <= 1'b0;
            1: bit_in <= 1'b1;
            2: bit_in <= cyc[0];
            default: bit_in <= ((cyc % 8) < 3);
        endcase
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic do_run(input int s2, input int drop, input int flip);
        int k;
        bcnt = 0;
        @(negedge clk); start <= 1'b1;
        @(negedge clk); start <= 1'b0;
        k = 1;
        while (busy && k < 20000) begin
            start   <= (k == s2);
            bit_vld <= !(drop != 0 && k >= drop && k < drop + 3);
            if (flip != 0 && k == flip) bip_mode <= !bip_mode;
            @(negedge clk);
            k++;
        end
        start <= 1'b0; bit_vld <= 1'b1;
        @(negedge clk);
    endtask

    task automatic check_result(input int eo, input int eg);
        chk(res_valid == 1'b1, "R8 res_valid after run", res_valid, 1);
        chk($signed(offset_err) == eo, "R4 offset value", $signed(offset_err), eo);
        chk($signed(gain_err) == eg, "R5 gain value", $signed(gain_err), eg);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !mod_reset && !zero_force && !gain_force, "R1 controls idle", busy, 0);
        chk(!res_pulse && !res_valid, "R1 flags low", res_valid, 0);
        chk(offset_err == '0 && gain_err == '0, "R1 errors zero", offset_err, 0);
        rst_n <= 1'b1;
        repeat (3) @(negedge clk);

        // run A: bipolar, all ones, stray start while busy (R2)
        bip_mode <= 1'b1; pat = 1;
        do_run(300, 0, 0);
        chk(bcnt == RUNLEN, "R2 busy length, start ignored", bcnt, RUNLEN);
        check_result(WIN / 2, WIN - (5 * WIN) / 8);

        // run B: unipolar, all zeros
        bip_mode <= 1'b0; pat = 0;
        do_run(0, 0, 0);
        check_result(-(3 * WIN) / 8, -(5 * WIN) / 8);

        // run C: bipolar, alternating bits
        bip_mode <= 1'b1; pat = 2;
        do_run(0, 0, 0);
        check_result(0, WIN / 2 - (5 * WIN) / 8);

        // run D: unipolar, three ones in eight
        bip_mode <= 1'b0; pat = 3;
        do_run(0, 0, 0);
        check_result(0, (3 * WIN) / 8 - (5 * WIN) / 8);
        // R9: range change after completion clears validity
        bip_mode <= 1'b1;
        repeat (2) @(negedge clk);
        chk(res_valid == 1'b0, "R9 valid cleared on range change", res_valid, 0);

        // run E: valid drop in the zero count (R7)
        pat = 2;
        do_run(0, RST + SET + 20, 0);
        chk(bcnt >= RUNLEN + SET, "R7 restart adds full settle", bcnt, RUNLEN + SET);
        check_result(0, WIN / 2 - (5 * WIN) / 8);

        // run F: range change mid-run (R10)
        do_run(0, 0, 500);
        chk(busy == 1'b0, "R10 aborted to idle", busy, 0);
        chk(res_valid == 1'b0, "R10 no valid result", res_valid, 0);
        chk(bcnt < 600, "R10 run cut short", bcnt, 500);

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule